// File: doc/BRIEF.md
# Serial-Bus EEPROM Slave Protocol Engine

This block is the two-wire bus slave that sits in front of a 512-byte non-volatile array. The array is split into two halves of 256 bytes. A fast system clock samples the bus clock and data lines. The block finds bus start and stop conditions and decodes the device select byte. It acknowledges by pulling the data line low through an open-drain output enable. It also keeps the internal byte address counter that every read and write uses.

Write data bytes leave the block one at a time, each tagged with its 9-bit address, toward an external write controller. A stop at the end of a write asks that controller to commit the bytes. While the controller reports that it is busy programming, the block refuses to acknowledge any select byte. A bus master can therefore poll for completion. Reads fetch from a synchronous memory port through the block's address output and shift the bytes out MSB first. A read can start at the current counter, at an address loaded by a dummy write, or run on sequentially.

Top module: `sbus_eeprom_slave`

## Requirements
- R1: A select byte is acknowledged only when its bits 7..4 equal 1010 and its bits 3 and 2 equal `chip_sel[1]` and `chip_sel[0]`. Bit 1 is the block bit and bit 0 is 1 for read. On a mismatch the block leaves SDA released until the next START.
- R2: SDA falling while SCL is high (START) abandons any transfer in progress and begins select-byte reception. SDA rising while SCL is high (STOP) returns the block to idle.
- R3: After an accepted select byte, an accepted address byte or an accepted write data byte, the block holds SDA low for the whole of the 9th clock and releases it after that clock falls.
- R4: While `wr_busy` is high, a matching select byte gets no acknowledge and produces no write byte and no commit.
- R5: Every write data byte that follows a write select and an address byte appears as a one-cycle `wr_byte_valid` pulse. The pulse carries the byte and its 9-bit address, and bit 8 of that address is the select byte's block bit.
- R6: After each write data byte the counter's low 3 bits step modulo 8 and its upper 6 bits hold. A burst therefore wraps inside its 8-byte row.
- R7: A STOP that follows at least one write data byte raises `commit_req` for one cycle. A STOP or repeated START after only a select or an address byte (a dummy write) does not.
- R8: A read select that follows a dummy write returns the byte at the loaded address, MSB first.
- R9: A read select's block bit replaces bit 8 of the counter. A read with no preceding address returns the byte at the counter.
- R10: The counter adds 1 after each byte read, wrapping 0x1FF to 0x000. Reading continues for as long as the master acknowledges.
- R11: When the master does not acknowledge a read byte, the block releases SDA and drives nothing for any later clocks until the next START.
- R12: SDA drive changes only while SCL is low, `DRIVE_DLY` system clocks after the synchronized SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| chip_sel | input | 2 | Strapped address bits matched against select bits 3..2 |
| wr_busy | input | 1 | Write controller is programming the array |
| mem_addr | output | 9 | Read address to the synchronous memory |
| mem_rdata | input | 8 | Memory data, one cycle after `mem_addr` |
| wr_byte_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_byte_addr | output | 9 | Address of the write byte |
| wr_byte_data | output | 8 | Write byte value |
| commit_req | output | 1 | One-cycle request to program the collected bytes |

## Verification
The bench aims at the counter's two wrap rules. A burst write that crosses a row end must land back at the row start, and a design that carried into bit 3 would report the third byte at 0x040 and not 0x038. A sequential read from 0x1FE must go on to 0x000. The bench also polls during a programming cycle, where a block that ignored busy would acknowledge at once. It checks that a dummy write never commits, because a stray commit would program stale bytes. It aborts a select byte with a new START and then checks that the following read still lines up. After a NACK it clocks a whole extra byte, and any drive from the slave in that byte would be reported. A monitor flags any change of the SDA drive while SCL is high, since such a change looks to other devices like a false START or STOP.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int BYTE_W = 8;
  localparam int MEM_AW = 9;
  localparam int ROW_W  = 3;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } sbm_state_e;

  function automatic logic sel_match(input logic [BYTE_W-1:0] b, input logic [1:0] ce);
    return (b[7:4] == TYPE_CODE) && (b[3:2] == ce);
  endfunction

  function automatic logic [MEM_AW-1:0] rd_next(input logic [MEM_AW-1:0] a);
    return a + MEM_AW'(1);
  endfunction

  function automatic logic [MEM_AW-1:0] row_next(input logic [MEM_AW-1:0] a);
    logic [ROW_W-1:0] low;
    low = a[ROW_W-1:0] + ROW_W'(1);
    return {a[MEM_AW-1:ROW_W], low};
  endfunction
endpackage

// File: rtl/sbm_line_sync.sv
module sbm_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh[0] <= scl_i;
      sda_sh[0] <= sda_i;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        scl_sh[k] <= scl_sh[k-1];
        sda_sh[k] <= sda_sh[k-1];
      end
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/sbm_drive_dly.sv
module sbm_drive_dly #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_low,
  input  logic scl_s,
  output logic sda_oe
);
  generate
    if (DLY == 0) begin : g_direct
      assign sda_oe = want_low;
    end else begin : g_pipe
      logic [DLY-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else begin
          stage_q[0] <= want_low;
          for (int k = 1; k < DLY; k++) stage_q[k] <= stage_q[k-1];
        end
      end
      assign sda_oe = stage_q[DLY-1];
    end
  endgenerate

  // Pulling the line low while SCL is high would read as a START.
  p_pull_while_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

// File: rtl/sbm_addr_ctr.sv
module sbm_addr_ctr
  import sbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_hi,
  input  logic              hi_val,
  input  logic              load_lo,
  input  logic [BYTE_W-1:0] lo_val,
  input  logic              inc_row,
  input  logic              inc_rd,
  output logic [MEM_AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else if (set_hi)  addr[MEM_AW-1] <= hi_val;
    else if (load_lo) addr[BYTE_W-1:0] <= lo_val;
    else if (inc_row) addr <= row_next(addr);
    else if (inc_rd)  addr <= rd_next(addr);
  end

  p_row_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_row |=> addr[MEM_AW-1:ROW_W] == $past(addr[MEM_AW-1:ROW_W]));

  p_read_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_rd && !set_hi && !load_lo && !inc_row && addr == '1) |=> addr == '0);
endmodule

// File: rtl/sbus_eeprom_slave.sv
module sbus_eeprom_slave
  import sbm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DRIVE_DLY   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        chip_sel,
  input  logic              wr_busy,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              wr_byte_valid,
  output logic [MEM_AW-1:0] wr_byte_addr,
  output logic [BYTE_W-1:0] wr_byte_data,
  output logic              commit_req
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  sbm_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  sbm_state_e        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              want_low, rw_q, mack_q, wr_pending;

  // Named events, shared by the counter controls and the assertions.
  logic rx_phase, byte_end, sel_ok, rd_byte_end;
  assign rx_phase    = (state == ST_DEV) || (state == ST_ADDR) || (state == ST_WDATA);
  assign byte_end    = scl_fall && (bitcnt == CNT_W'(BYTE_W));
  assign sel_ok      = sel_match(rx_sh, chip_sel) && !wr_busy;
  assign rd_byte_end = (state == ST_RDATA) && byte_end;

  logic ctr_set_hi, ctr_load_lo, ctr_inc_row;
  assign ctr_set_hi  = !start_evt && !stop_evt && (state == ST_DEV) && byte_end && sel_ok;
  assign ctr_load_lo = !start_evt && !stop_evt && (state == ST_ADDR) && byte_end;
  assign ctr_inc_row = !start_evt && !stop_evt && (state == ST_WDATA) && byte_end;

  sbm_addr_ctr u_ctr (
    .clk(clk), .rst_n(rst_n),
    .set_hi(ctr_set_hi), .hi_val(rx_sh[1]),
    .load_lo(ctr_load_lo), .lo_val(rx_sh),
    .inc_row(ctr_inc_row),
    .inc_rd(!start_evt && !stop_evt && rd_byte_end),
    .addr(mem_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      bitcnt        <= '0;
      rx_sh         <= '0;
      tx_sh         <= '0;
      want_low      <= 1'b0;
      rw_q          <= 1'b0;
      mack_q        <= 1'b0;
      wr_pending    <= 1'b0;
      wr_byte_valid <= 1'b0;
      wr_byte_addr  <= '0;
      wr_byte_data  <= '0;
      commit_req    <= 1'b0;
    end else begin
      wr_byte_valid <= 1'b0;
      commit_req    <= 1'b0;
      if (start_evt) begin
        state      <= ST_DEV;
        bitcnt     <= '0;
        want_low   <= 1'b0;
        wr_pending <= 1'b0;
      end else if (stop_evt) begin
        state      <= ST_IDLE;
        want_low   <= 1'b0;
        commit_req <= wr_pending;
        wr_pending <= 1'b0;
      end else begin
        if (scl_rise && rx_phase && bitcnt < CNT_W'(BYTE_W)) begin
          rx_sh  <= {rx_sh[BYTE_W-2:0], sda_s};
          bitcnt <= bitcnt + CNT_W'(1);
        end
        if (scl_rise && state == ST_RDATA && bitcnt < CNT_W'(BYTE_W))
          bitcnt <= bitcnt + CNT_W'(1);
        case (state)
          ST_DEV: if (byte_end) begin
            if (sel_ok) begin
              want_low <= 1'b1;
              rw_q     <= rx_sh[0];
              state    <= ST_DEV_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_DEV_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rw_q) begin
              state    <= ST_RDATA;
              tx_sh    <= mem_rdata;
              want_low <= ~mem_rdata[BYTE_W-1];
            end else begin
              state    <= ST_ADDR;
              want_low <= 1'b0;
            end
          end
          ST_ADDR: if (byte_end) begin
            want_low <= 1'b1;
            state    <= ST_ADDR_ACK;
          end
          ST_ADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
            want_low <= 1'b0;
            bitcnt   <= '0;
            state    <= ST_WDATA;
          end
          ST_WDATA: if (byte_end) begin
            want_low      <= 1'b1;
            wr_byte_valid <= 1'b1;
            wr_byte_addr  <= mem_addr;
            wr_byte_data  <= rx_sh;
            wr_pending    <= 1'b1;
            state         <= ST_WDATA_ACK;
          end
          ST_RDATA: if (scl_fall) begin
            if (bitcnt == CNT_W'(BYTE_W)) begin
              want_low <= 1'b0;
              state    <= ST_RACK;
            end else if (bitcnt != '0) begin
              tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
              want_low <= ~tx_sh[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                state    <= ST_RDATA;
                bitcnt   <= '0;
                tx_sh    <= mem_rdata;
                want_low <= ~mem_rdata[BYTE_W-1];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  sbm_drive_dly #(.DLY(DRIVE_DLY)) u_drv (
    .clk(clk), .rst_n(rst_n), .want_low(want_low), .scl_s(scl_s), .sda_oe(sda_oe));

  p_start_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> state == ST_DEV);

  p_stop_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> state == ST_IDLE);

  p_busy_no_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV && byte_end && wr_busy && !start_evt && !stop_evt) |=> state == ST_IDLE);

  p_commit_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> $past(stop_evt));

  p_strobes_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_byte_valid, commit_req}));

  p_idle_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !want_low);
endmodule

// File: tb/sbus_eeprom_slave_tb_top.sv
module sbus_eeprom_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 16;
  localparam int BUSY_CYC   = 2500;
  localparam logic [1:0] CE = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_line, sda_oe, wr_busy, wr_byte_valid, commit_req;
  logic [8:0] mem_addr, wr_byte_addr;
  logic [7:0] mem_rdata, wr_byte_data;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  sbus_eeprom_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .chip_sel(CE), .wr_busy(wr_busy), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wr_byte_valid(wr_byte_valid), .wr_byte_addr(wr_byte_addr),
    .wr_byte_data(wr_byte_data), .commit_req(commit_req));

  function automatic logic [7:0] seed_val(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // Memory and write-controller model.
  logic [7:0] mem [512];
  logic [8:0] pa [8];
  logic [7:0] pd [8];
  int pn, bcnt, ev_n, commits, oe_cycles, glitches;
  logic [8:0] ev_a [16];
  logic [7:0] ev_d [16];
  logic oe_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= seed_val(i);
      wr_busy <= 1'b0; bcnt <= 0; pn <= 0; ev_n <= 0; commits <= 0;
      oe_cycles <= 0; glitches <= 0; oe_prev <= 1'b0; mem_rdata <= 8'h00;
    end else begin
      mem_rdata <= mem[mem_addr];
      oe_prev <= sda_oe;
      if (sda_oe) oe_cycles <= oe_cycles + 1;
      if (sda_oe != oe_prev && m_scl) glitches <= glitches + 1;
      if (wr_byte_valid) begin
        if (pn < 8) begin pa[pn] <= wr_byte_addr; pd[pn] <= wr_byte_data; pn <= pn + 1; end
        if (ev_n < 16) begin ev_a[ev_n] <= wr_byte_addr; ev_d[ev_n] <= wr_byte_data; end
        ev_n <= ev_n + 1;
      end
      if (commit_req) begin
        wr_busy <= 1'b1; bcnt <= BUSY_CYC; commits <= commits + 1;
      end else if (wr_busy) begin
        if (bcnt == 1) begin
          for (int k = 0; k < pn; k++) mem[pa[k]] <= pd[k];
          pn <= 0; wr_busy <= 1'b0;
        end
        bcnt <= bcnt - 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
    ack = !sda_line;
    qw(); m_scl = 1'b0; qw();
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
      d[i] = sda_line;
      qw(); m_scl = 1'b0; qw();
    end
    send_bit(mack ? 1'b0 : 1'b1);
  endtask

  function automatic logic [7:0] sel(input bit a8, input bit rd);
    return {4'b1010, CE, a8, rd};
  endfunction

  task automatic wait_idle();
    while (wr_busy) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R11 reset released", sda_oe, 0);
    chk(commit_req == 1'b0 && wr_byte_valid == 1'b0, "R7 reset strobes", commit_req, 0);
  endtask

  task automatic t_bad_select();
    bit a;
    int oe0;
    bus_start();
    write_byte({4'b1010, ~CE, 2'b00}, a);
    chk(!a, "R1 chip bits mismatch", a, 0);
    oe0 = oe_cycles;
    write_byte(8'hFF, a);
    chk(oe_cycles == oe0, "R1 silent after mismatch", oe_cycles - oe0, 0);
    bus_start();
    write_byte({4'b1011, CE, 2'b00}, a);
    chk(!a, "R1 type code mismatch", a, 0);
    bus_stop();
  endtask

  task automatic t_row_write();
    bit a0, a1, a2, a3, a4;
    bus_start();
    write_byte(sel(0, 0), a0);
    write_byte(8'h3E, a1);
    write_byte(8'h11, a2);
    write_byte(8'h22, a3);
    write_byte(8'h33, a4);
    chk(a0 && a1 && a2 && a3 && a4, "R3 acks on write", {a0, a1, a2, a3, a4}, 31);
    bus_stop();
    chk(ev_n == 3, "R5 byte count", ev_n, 3);
    chk(ev_a[0] == 9'h03E && ev_d[0] == 8'h11, "R5 first byte", ev_a[0], 9'h03E);
    chk(ev_a[1] == 9'h03F && ev_d[1] == 8'h22, "R6 second byte", ev_a[1], 9'h03F);
    chk(ev_a[2] == 9'h038 && ev_d[2] == 8'h33, "R6 row wrap", ev_a[2], 9'h038);
    chk(commits == 1, "R7 commit on stop", commits, 1);
  endtask

  task automatic t_busy_poll();
    bit a;
    int polls = 0;
    bus_start();
    write_byte(sel(0, 0), a);
    chk(!a && wr_busy, "R4 no ack while busy", a, 0);
    bus_stop();
    chk(ev_n == 3 && commits == 1, "R4 no strobes while busy", ev_n, 3);
    a = 1'b0;
    while (!a && polls < 12) begin
      bus_start();
      write_byte(sel(0, 0), a);
      bus_stop();
      polls++;
    end
    chk(a && polls > 1, "R4 ack after busy ends", polls, 2);
    chk(commits == 1, "R7 no commit from poll", commits, 1);
  endtask

  task automatic t_block1_write();
    bit a0, a1, a2;
    bus_start();
    write_byte(sel(1, 0), a0);
    write_byte(8'h10, a1);
    write_byte(8'hA5, a2);
    bus_stop();
    chk(ev_a[3] == 9'h110 && ev_d[3] == 8'hA5, "R5 block bit in address", ev_a[3], 9'h110);
    wait_idle();
  endtask

  task automatic t_random_read();
    bit a0, a1, a2;
    logic [7:0] d;
    int c0 = commits;
    bus_start();
    write_byte(sel(0, 0), a0);
    write_byte(8'h3F, a1);
    bus_start();
    write_byte(sel(0, 1), a2);
    read_byte(1'b0, d);
    bus_stop();
    chk(a0 && a1 && a2, "R3 acks on random read", {a0, a1, a2}, 7);
    chk(d == 8'h22, "R8 random read data", d, 8'h22);
    chk(commits == c0, "R7 dummy write no commit", commits, c0);
  endtask

  task automatic t_current_read();
    bit a;
    logic [7:0] d;
    bus_start();
    write_byte(sel(0, 1), a);
    read_byte(1'b0, d);
    bus_stop();
    chk(d == seed_val(9'h040), "R9 current read", d, seed_val(9'h040));
  endtask

  task automatic t_start_abort();
    bit a;
    logic [7:0] d;
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    write_byte(sel(1, 1), a);
    read_byte(1'b0, d);
    bus_stop();
    chk(a, "R2 select after abort", a, 1);
    chk(d == seed_val(9'h141), "R9 block bit overrides", d, seed_val(9'h141));
  endtask

  task automatic t_block0_after_block1();
    bit a;
    logic [7:0] d;
    bus_start();
    write_byte(sel(0, 1), a);
    read_byte(1'b0, d);
    bus_stop();
    chk(d == seed_val(9'h042), "R10 counter after read", d, seed_val(9'h042));
  endtask

  task automatic t_seq_wrap();
    bit a0, a1, a2, a3;
    logic [7:0] d0, d1, d2, dx;
    int oe0;
    bus_start();
    write_byte(sel(1, 0), a0);
    write_byte(8'hFE, a1);
    bus_start();
    write_byte(sel(1, 1), a2);
    read_byte(1'b1, d0);
    read_byte(1'b1, d1);
    read_byte(1'b0, d2);
    chk(d0 == seed_val(9'h1FE), "R10 seq byte 0", d0, seed_val(9'h1FE));
    chk(d1 == seed_val(9'h1FF), "R10 seq byte 1", d1, seed_val(9'h1FF));
    chk(d2 == seed_val(9'h000), "R10 wrap to 0", d2, seed_val(9'h000));
    #(CLK_PERIOD * 12);
    oe0 = oe_cycles;
    read_byte(1'b0, dx);
    write_byte(8'h00, a3);
    chk(oe_cycles == oe0, "R11 no drive after nack", oe_cycles - oe0, 0);
    bus_stop();
  endtask

  task automatic t_stop_after_select();
    bit a;
    int c0 = commits, e0 = ev_n;
    bus_start();
    write_byte(sel(0, 0), a);
    bus_stop();
    chk(a && commits == c0 && ev_n == e0, "R2 stop after select", commits, c0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    t_bad_select();
    t_row_write();
    t_busy_poll();
    t_block1_write();
    t_random_read();
    t_current_read();
    t_start_abort();
    t_block0_after_block1();
    t_seq_wrap();
    t_stop_after_select();
    chk(glitches == 0, "R12 drive change under SCL high", glitches, 0);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule